// File: doc/BRIEF.md
# Fractional-Delay Linear Interpolator

This block resamples a complex baseband stream taken at four samples per chip and delivers two samples per chip to the despreading and timing-error logic. Every second accepted input sample completes a pair, and each completed pair yields one output sample. The outputs alternate between an on-time sample and an early/late sample, half a chip apart.

The sampling instant is set by a timing loop that lives outside the block. It supplies an integer sample offset and a fractional weight. The integer offset picks two neighbouring input samples from a short delay line. The fractional weight mixes them linearly: the output is the older tap plus the rounded, weighted difference between the taps. The I and Q rails share the tap selection and the weight.

A new delay value is taken only with the first sample of a symbol, so every symbol is interpolated at a single timing instant. The same sample restarts the pair grouping and the on-time/early-late sequence.

Top module: `frac_delay_interp`

## Requirements
- R1: After reset, `out_vld_o`, `out_i_o`, `out_q_o` and `out_el_o` are all 0, and the delay line holds zeros.
- R2: One output is produced for every two accepted input samples. The first sample of a pair produces no output. `out_vld_o` is high for exactly one cycle, in the cycle after the clock edge that captures the second sample of the pair.
- R3: `out_el_o` is 0 for an on-time sample and 1 for an early/late sample. The value alternates on successive outputs, and the first output after a symbol start is on-time (0).
- R4: When a pair completes, let s(0) be the newest accepted sample and s(k) the sample accepted k samples before it. With integer delay l (0..3), the output mixes s(4-l) (older tap A) and s(3-l) (newer tap B).
- R5: Per rail, the output is A + floor(((B-A)·f + 16) / 32), where f is the 5-bit fractional weight (0..31, weight f/32 on tap B). This rounds to nearest with ties upward. All samples are 7-bit two's complement.
- R6: With f = 0, the output equals tap A exactly.
- R7: `int_del_i` and `frac_del_i` are loaded only when `smp_vld_i` and `sym_start_i` are both high. Changes at any other time, including `sym_start_i` without `smp_vld_i`, have no effect on the outputs.
- R8: A sample accepted with `sym_start_i` high counts as the first sample of a new pair, even when the previous pair was incomplete.
- R9: The I and Q rails are processed independently with the same taps and weight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_vld_i | input | 1 | Input sample valid, one strobe per quarter-chip sample |
| smp_i_i | input | 7 | Input sample, I rail, signed |
| smp_q_i | input | 7 | Input sample, Q rail, signed |
| sym_start_i | input | 1 | Marks the accompanying sample as the first of a symbol |
| int_del_i | input | 2 | Integer sample offset requested by the timing loop |
| frac_del_i | input | 5 | Fractional weight requested by the timing loop (units of 1/32) |
| out_vld_o | output | 1 | Output sample valid |
| out_i_o | output | 7 | Interpolated sample, I rail, signed |
| out_q_o | output | 7 | Interpolated sample, Q rail, signed |
| out_el_o | output | 1 | 0 = on-time sample, 1 = early/late sample |

## Verification
The assertions assume that `sym_start_i` carries meaning only together with `smp_vld_i`. They also assume that the output register sees the same taps in the cycle it loads as the checker sees one cycle later through `$past`; this holds because the register and the checker are clocked on the same edge.

The bench presents one sample at a time, with at least one idle cycle after each sample. Every symbol start comes with a valid sample, except one deliberate strobe without a sample, which is used to show that such a strobe is ignored. Weights and integer offsets stay within their field ranges, so the timing loop is modelled only by explicit per-symbol delay values.

// File: rtl/fdi_pkg.sv
package fdi_pkg;
  localparam int unsigned DEF_SMP_W  = 7;
  localparam int unsigned DEF_INT_W  = 2;
  localparam int unsigned DEF_FRAC_W = 5;
  localparam int unsigned N_RAIL     = 2;
  localparam int unsigned RAIL_I     = 0;
  localparam int unsigned RAIL_Q     = 1;

  typedef enum logic {
    PH_ONTIME = 1'b0,
    PH_EL     = 1'b1
  } half_e;
endpackage

// File: rtl/fdi_ctrl.sv
module fdi_ctrl
  import fdi_pkg::*;
#(
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic              sym_start_i,
  input  logic [INT_W-1:0]  int_del_i,
  input  logic [FRAC_W-1:0] frac_del_i,
  output logic              calc_o,
  output half_e             phase_o,
  output logic [INT_W-1:0]  int_act_o,
  output logic [FRAC_W-1:0] frac_act_o
);
  logic              held_q;
  logic              calc_q;
  half_e             ph_q;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              sym_acc;

  assign sym_acc = smp_vld_i & sym_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      calc_q <= 1'b0;
      ph_q   <= PH_ONTIME;
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      calc_q <= smp_vld_i & ~sym_start_i & held_q;
      if (smp_vld_i) held_q <= sym_start_i ? 1'b1 : ~held_q;
      // symbol start wins over the toggle of a pair finishing this cycle
      if (sym_acc) begin
        int_q  <= int_del_i;
        frac_q <= frac_del_i;
        ph_q   <= PH_ONTIME;
      end else if (calc_q) begin
        ph_q <= (ph_q == PH_ONTIME) ? PH_EL : PH_ONTIME;
      end
    end
  end

  assign calc_o     = calc_q;
  assign phase_o    = ph_q;
  assign int_act_o  = int_q;
  assign frac_act_o = frac_q;
endmodule

// File: rtl/fdi_tap_line.sv
module fdi_tap_line
  import fdi_pkg::*;
#(
  parameter int unsigned SMP_W = DEF_SMP_W,
  parameter int unsigned INT_W = DEF_INT_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    shift_i,
  input  logic signed [SMP_W-1:0] din_i,
  input  logic [INT_W-1:0]        sel_i,
  output logic signed [SMP_W-1:0] tap_a_o,
  output logic signed [SMP_W-1:0] tap_b_o
);
  localparam int unsigned BASE  = 1 << INT_W;
  localparam int unsigned DEPTH = BASE + 1;

  logic signed [SMP_W-1:0] line_q [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        line_q[k] <= '0;
      end else if (shift_i) begin
        if (k == 0) line_q[k] <= din_i;
        else        line_q[k] <= line_q[k-1];
      end
    end
  end

  // index 0 is the newest sample; larger offsets move both taps toward it
  always_comb begin
    tap_a_o = line_q[BASE - int'(sel_i)];
    tap_b_o = line_q[BASE - 1 - int'(sel_i)];
  end
endmodule

// File: rtl/fdi_blend.sv
module fdi_blend
  import fdi_pkg::*;
#(
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic signed [SMP_W-1:0] tap_a_i,
  input  logic signed [SMP_W-1:0] tap_b_i,
  input  logic [FRAC_W-1:0]       frac_i,
  output logic signed [SMP_W-1:0] y_o
);
  localparam int unsigned DW   = SMP_W + 1;
  localparam int unsigned PW   = DW + FRAC_W + 1;
  localparam int unsigned SW   = PW + 1;
  localparam int          HALF = 1 << (FRAC_W - 1);
  localparam logic signed [SW-1:0] MAX_V = SW'((1 <<< (SMP_W - 1)) - 1);
  localparam logic signed [SW-1:0] MIN_V = -MAX_V - SW'(1);

  logic signed [DW-1:0] diff;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] rnd;
  logic signed [PW-1:0] step;
  logic signed [SW-1:0] sum;

  always_comb begin
    diff = {tap_b_i[SMP_W-1], tap_b_i} - {tap_a_i[SMP_W-1], tap_a_i};
    prod = PW'(diff) * $signed(PW'({1'b0, frac_i}));
    rnd  = prod + PW'(HALF);
    step = rnd >>> FRAC_W;
    sum  = SW'(step) + SW'(tap_a_i);
    if (sum > MAX_V)      y_o = MAX_V[SMP_W-1:0];
    else if (sum < MIN_V) y_o = MIN_V[SMP_W-1:0];
    else                  y_o = sum[SMP_W-1:0];
  end
endmodule

// File: rtl/frac_delay_interp.sv
module frac_delay_interp
  import fdi_pkg::*;
#(
  parameter int unsigned SMP_W  = DEF_SMP_W,
  parameter int unsigned INT_W  = DEF_INT_W,
  parameter int unsigned FRAC_W = DEF_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              smp_vld_i,
  input  logic [SMP_W-1:0]  smp_i_i,
  input  logic [SMP_W-1:0]  smp_q_i,
  input  logic              sym_start_i,
  input  logic [INT_W-1:0]  int_del_i,
  input  logic [FRAC_W-1:0] frac_del_i,
  output logic              out_vld_o,
  output logic [SMP_W-1:0]  out_i_o,
  output logic [SMP_W-1:0]  out_q_o,
  output logic              out_el_o
);
  logic              calc;
  half_e             phase;
  logic [INT_W-1:0]  int_act;
  logic [FRAC_W-1:0] frac_act;

  logic signed [SMP_W-1:0] din   [N_RAIL];
  logic signed [SMP_W-1:0] tap_a [N_RAIL];
  logic signed [SMP_W-1:0] tap_b [N_RAIL];
  logic signed [SMP_W-1:0] y     [N_RAIL];
  logic signed [SMP_W-1:0] out_q [N_RAIL];
  logic                    vld_q;
  half_e                   el_q;

  assign din[RAIL_I] = smp_i_i;
  assign din[RAIL_Q] = smp_q_i;

  fdi_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .smp_vld_i  (smp_vld_i),
    .sym_start_i(sym_start_i),
    .int_del_i  (int_del_i),
    .frac_del_i (frac_del_i),
    .calc_o     (calc),
    .phase_o    (phase),
    .int_act_o  (int_act),
    .frac_act_o (frac_act)
  );

  for (genvar r = 0; r < N_RAIL; r++) begin : g_rail
    fdi_tap_line #(.SMP_W(SMP_W), .INT_W(INT_W)) u_line (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(smp_vld_i),
      .din_i  (din[r]),
      .sel_i  (int_act),
      .tap_a_o(tap_a[r]),
      .tap_b_o(tap_b[r])
    );

    fdi_blend #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) u_blend (
      .tap_a_i(tap_a[r]),
      .tap_b_i(tap_b[r]),
      .frac_i (frac_act),
      .y_o    (y[r])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   out_q[r] <= '0;
      else if (calc) out_q[r] <= y[r];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      el_q  <= PH_ONTIME;
    end else begin
      vld_q <= calc;
      if (calc) el_q <= phase;
    end
  end

  assign out_vld_o = vld_q;
  assign out_i_o   = out_q[RAIL_I];
  assign out_q_o   = out_q[RAIL_Q];
  assign out_el_o  = el_q;
endmodule

// File: rtl/fdi_checker.sv
module fdi_checker #(
  parameter int unsigned SMP_W  = 7,
  parameter int unsigned FRAC_W = 5
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    smp_vld_i,
  input logic                    sym_start_i,
  input logic                    out_vld_o,
  input logic signed [SMP_W-1:0] out_i_o,
  input logic signed [SMP_W-1:0] out_q_o,
  input logic signed [SMP_W-1:0] ta_i,
  input logic signed [SMP_W-1:0] tb_i,
  input logic signed [SMP_W-1:0] ta_q,
  input logic signed [SMP_W-1:0] tb_q,
  input logic [FRAC_W-1:0]       frac_act
);
  assert_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |=> !out_vld_o);

  assert_src_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $past(smp_vld_i, 2));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smp_vld_i && sym_start_i) |=> $stable(frac_act));

  assert_bound_i_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> ((out_i_o >= $past(ta_i) && out_i_o <= $past(tb_i)) ||
                   (out_i_o >= $past(tb_i) && out_i_o <= $past(ta_i))));

  assert_bound_q_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> ((out_q_o >= $past(ta_q) && out_q_o <= $past(tb_q)) ||
                   (out_q_o >= $past(tb_q) && out_q_o <= $past(ta_q))));

  assert_zero_w_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_vld_o && $past(frac_act) == '0) |-> out_i_o == $past(ta_i));
endmodule

bind frac_delay_interp fdi_checker #(.SMP_W(SMP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .smp_vld_i  (smp_vld_i),
  .sym_start_i(sym_start_i),
  .out_vld_o  (out_vld_o),
  .out_i_o    (out_i_o),
  .out_q_o    (out_q_o),
  .ta_i       (tap_a[0]),
  .tb_i       (tap_b[0]),
  .ta_q       (tap_a[1]),
  .tb_q       (tap_b[1]),
  .frac_act   (frac_act)
);

// File: tb/frac_delay_interp_tb_top.sv
module frac_delay_interp_tb_top;
  localparam int SW = 7;
  localparam int IW = 2;
  localparam int FW = 5;
  localparam int BASE = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_vld = 1'b0;
  logic [SW-1:0] smp_i = '0;
  logic [SW-1:0] smp_q = '0;
  logic          sym_start = 1'b0;
  logic [IW-1:0] int_del = '0;
  logic [FW-1:0] frac_del = '0;
  logic          out_vld;
  logic [SW-1:0] out_i;
  logic [SW-1:0] out_q;
  logic          out_el;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  int hist_i [BASE+1];
  int hist_q [BASE+1];
  int m_l = 0, m_f = 0, m_held = 0, m_ph = 0;

  always #5 clk = ~clk;

  frac_delay_interp dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_vld_i(smp_vld), .smp_i_i(smp_i),
    .smp_q_i(smp_q), .sym_start_i(sym_start), .int_del_i(int_del),
    .frac_del_i(frac_del), .out_vld_o(out_vld), .out_i_o(out_i),
    .out_q_o(out_q), .out_el_o(out_el)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int blend(int a, int b, int f);
    int s;
    s = a + (((b - a) * f + (1 << (FW - 1))) >>> FW);
    if (s > 63) s = 63;
    if (s < -64) s = -64;
    return s;
  endfunction

  function automatic int sx(logic [SW-1:0] v);
    return int'($signed(v));
  endfunction

  // drive one sample, update the model, check the output that follows
  task automatic push(int si, int sq, bit sym, int l, int f, string req);
    bit due;
    @(negedge clk);
    smp_vld = 1'b1; smp_i = SW'(si); smp_q = SW'(sq);
    sym_start = sym; int_del = IW'(l); frac_del = FW'(f);
    @(posedge clk);
    for (int k = BASE; k > 0; k--) begin
      hist_i[k] = hist_i[k-1];
      hist_q[k] = hist_q[k-1];
    end
    hist_i[0] = si; hist_q[0] = sq;
    due = 1'b0;
    if (sym) begin
      m_l = l; m_f = f; m_held = 1; m_ph = 0;
    end else if (m_held == 1) begin
      due = 1'b1; m_held = 0;
    end else begin
      m_held = 1;
    end
    @(negedge clk);
    smp_vld = 1'b0; sym_start = 1'b0;
    chk("R2", "vld in capture cycle", int'(out_vld), 0);
    if (due) begin
      @(negedge clk);
      chk("R2", "vld after pair", int'(out_vld), 1);
      chk(req, "out_i", sx(out_i), blend(hist_i[BASE-m_l], hist_i[BASE-1-m_l], m_f));
      chk("R9", "out_q", sx(out_q), blend(hist_q[BASE-m_l], hist_q[BASE-1-m_l], m_f));
      chk("R3", "phase", int'(out_el), m_ph);
      m_ph ^= 1;
    end
  endtask

  task automatic t_reset();
    chk("R1", "vld", int'(out_vld), 0);
    chk("R1", "out_i", sx(out_i), 0);
    chk("R1", "out_q", sx(out_q), 0);
    chk("R1", "el", int'(out_el), 0);
  endtask

  task automatic t_tap_select();
    for (int l = 0; l < BASE; l++) begin
      push(l * 10 + 1, -(l * 10 + 1), 1'b1, l, 0, "R4");
      for (int k = 2; k <= 6; k++) push(l * 10 + k, -(l * 10 + k), 1'b0, l, 0, "R6");
    end
  endtask

  task automatic t_fraction();
    int fs [4] = '{16, 1, 31, 7};
    foreach (fs[j]) begin
      push(30, -5, 1'b1, 1, fs[j], "R5");
      push(-20, 17, 1'b0, 1, fs[j], "R5");
      push(9, -33, 1'b0, 1, fs[j], "R5");
      push(-41, 50, 1'b0, 1, fs[j], "R5");
      push(3, 3, 1'b0, 1, fs[j], "R5");
      push(-6, 22, 1'b0, 1, fs[j], "R5");
    end
  endtask

  task automatic t_extremes();
    push(-64, 63, 1'b1, 3, 31, "R5");
    push(63, -64, 1'b0, 3, 31, "R5");
    push(-64, 63, 1'b0, 3, 31, "R5");
    push(63, -64, 1'b0, 3, 31, "R5");
    push(63, 0, 1'b1, 2, 16, "R5");
    push(-64, 0, 1'b0, 2, 16, "R5");
    push(63, 0, 1'b0, 2, 16, "R5");
    push(-64, 0, 1'b0, 2, 16, "R5");
  endtask

  task automatic t_hold();
    push(11, 5, 1'b1, 2, 8, "R7");
    push(-13, 25, 1'b0, 0, 31, "R7");
    push(40, -2, 1'b0, 3, 0, "R7");
    push(-7, 8, 1'b0, 1, 20, "R7");
    // symbol strobe with no sample must be ignored
    @(negedge clk);
    sym_start = 1'b1; int_del = 2'd0; frac_del = 5'd0;
    @(negedge clk);
    sym_start = 1'b0;
    chk("R7", "vld after lone strobe", int'(out_vld), 0);
    push(22, -30, 1'b0, 0, 0, "R7");
    push(-50, 14, 1'b0, 0, 0, "R7");
    push(5, 61, 1'b0, 3, 3, "R7");
    push(-19, -19, 1'b0, 3, 3, "R7");
  endtask

  task automatic t_realign();
    push(1, 2, 1'b1, 0, 12, "R8");
    push(3, 4, 1'b0, 0, 12, "R8");
    push(5, 6, 1'b0, 0, 12, "R8");
    // odd sample left hanging, then a new symbol restarts the pair
    push(7, 8, 1'b1, 1, 24, "R8");
    push(9, 10, 1'b0, 1, 24, "R8");
    push(-11, 12, 1'b0, 1, 24, "R8");
    push(13, -14, 1'b0, 1, 24, "R8");
    push(-15, -16, 1'b0, 1, 24, "R3");
    push(17, 18, 1'b0, 1, 24, "R3");
  endtask

  task automatic t_rails();
    push(40, -40, 1'b1, 2, 5, "R9");
    push(-40, 40, 1'b0, 2, 5, "R9");
    push(0, 63, 1'b0, 2, 5, "R9");
    push(63, 0, 1'b0, 2, 5, "R9");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    for (int k = 0; k <= BASE; k++) begin
      hist_i[k] = 0;
      hist_q[k] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_tap_select();
    t_fraction();
    t_extremes();
    t_hold();
    t_realign();
    t_rails();
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule